// File: doc/BRIEF.md
# Descriptor Queue Manager

This block holds numbered hardware queues of descriptor words. Each queue is a first-in first-out list reached through a single bus register. A write to that register appends a word and a read removes the oldest word. A producer writes a word that packs a descriptor address with a small size hint in its low bits, and a consumer later reads the same word back from the same queue.

A packed status bitmap, spread over several read-only pending registers, shows which queues currently hold entries. Queues numbered 93 and upward are completion queues. A level-sensitive interrupt stays high for as long as any of them holds an entry. The descriptor memory region is described by a base register and a control register. Both are plain storage that software sets up and reads back.

The bus is a simple strobe interface. A write completes in the cycle it is presented. Read data returns one cycle after the read strobe, with a valid flag. When both strobes are high in the same cycle, the write is performed and the read is ignored.

Top module: `qdesc_qmgr`

## Requirements
- R1: After reset every queue is empty, all pending registers read 0, `irq` is low and `regRvalid` is low.
- R2: A write to address 0x200C + 0x10*n (n < 160) appends the 32-bit write word to queue n. A read of that address removes and returns the oldest word. Words leave in the order they entered.
- R3: A returned word matches the written word in all 32 bits, including a size hint held in the low bits. For example, a 64-byte descriptor carries the hint (64-24)/4 = 10.
- R4: A read of an empty queue returns 0 and leaves the queue empty.
- R5: The pending register at 0x90 + 4*i (i < 5) has bit b set exactly when queue 32*i+b holds at least one entry. A read issued in the cycle after a push or pop already reflects that push or pop.
- R6: `irq` is high while any of queues 93..159 holds an entry. Entries in queues 0..92 never raise it.
- R7: Each queue holds up to 4 entries. A push to a full queue is dropped without changing the queue, and it sets a sticky overflow flag. The flag is read in bit 0 at address 0x0C0. Writing 1 to bit 0 of that address clears the flag, and writing 0 there has no effect.
- R8: The region base register (0x1000) and the region control register (0x1004) read back the last word written to them. The control word is stored verbatim in the layout start index [31:16], log2(descriptor bytes)-5 [15:8], log2(descriptor count)-5 [7:0].
- R9: Read data appears on `regRdata` with `regRvalid` high exactly one cycle after the read strobe. Reads of unmapped addresses return 0.
- R10: Writes to unmapped addresses, including the other offsets inside a queue's 16-byte slot, change no queue and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 16 | Byte address of the access |
| regWrite | input | 1 | Write strobe (wins over a read in the same cycle) |
| regRead | input | 1 | Read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid with regRvalid |
| regRvalid | output | 1 | Read data valid, one cycle after regRead |
| irq | output | 1 | Level interrupt: a completion queue is non-empty |

## Verification
Queues are first exercised with multi-entry bursts, which reveal any reordering or merging across entries. Words with non-zero low bits are pushed to check that the size hint passes through untouched. Pushes land on queues on either side of the 93 boundary and on the highest queue, which separates the interrupt mask and the packing of the last pending register from the plain bitmap. Filling a queue past its depth, writing into non-pop offsets of a queue slot, and reading empty queues then separate dropped, ignored and zero-returning accesses from real pushes and pops.

// File: rtl/qm_pkg.sv
package qm_pkg;

  localparam int QIDX_W = 8;   // queue index width (up to 256 queues)
  localparam int PIDX_W = 3;   // pending register index width
  localparam int PEND_W = 32;  // bits per pending register

  localparam logic [15:0] QREG_BASE     = 16'h200C;
  localparam logic [15:0] PEND_BASE     = 16'h0090;
  localparam logic [15:0] OVF_ADDR      = 16'h00C0;
  localparam logic [15:0] RGN_BASE_ADDR = 16'h1000;
  localparam logic [15:0] RGN_CTL_ADDR  = 16'h1004;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_QUEUE,
    RD_PEND,
    RD_OVF,
    RD_BASE,
    RD_CTL
  } rdSrc_e;

  typedef struct packed {
    logic              push;
    logic              rd;
    rdSrc_e            src;
    logic              ovfClr;
    logic              baseWr;
    logic              ctlWr;
    logic [QIDX_W-1:0] qIdx;
    logic [PIDX_W-1:0] pendIdx;
  } qmStrobes_t;

endpackage

// File: rtl/qm_ctrl.sv
module qm_ctrl
  import qm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_QUEUES = 160,
  parameter int NUM_PEND   = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic              clrBit,
  output qmStrobes_t        strobes
);

  localparam logic [ADDR_W-1:0] NQ_A = ADDR_W'(NUM_QUEUES);
  localparam logic [ADDR_W-1:0] NP_A = ADDR_W'(NUM_PEND);
  localparam logic [ADDR_W-1:0] QB_A = ADDR_W'(QREG_BASE);
  localparam logic [ADDR_W-1:0] PB_A = ADDR_W'(PEND_BASE);

  logic [ADDR_W-1:0] offQ;
  logic [ADDR_W-1:0] offP;
  logic              qHit;
  logic              pHit;
  logic              ovfHit;
  logic              baseHit;
  logic              ctlHit;

  always_comb begin
    offQ    = regAddr - QB_A;
    offP    = regAddr - PB_A;
    qHit    = (regAddr >= QB_A) && (offQ[3:0] == 4'h0) && ((offQ >> 4) < NQ_A);
    pHit    = (regAddr >= PB_A) && (offP[1:0] == 2'b00) && ((offP >> 2) < NP_A);
    ovfHit  = (regAddr == ADDR_W'(OVF_ADDR));
    baseHit = (regAddr == ADDR_W'(RGN_BASE_ADDR));
    ctlHit  = (regAddr == ADDR_W'(RGN_CTL_ADDR));
  end

  always_comb begin
    strobes         = '0;
    strobes.src     = RD_NONE;
    strobes.qIdx    = QIDX_W'(offQ >> 4);
    strobes.pendIdx = PIDX_W'(offP >> 2);
    if (regWrite) begin
      strobes.push   = qHit;
      strobes.ovfClr = ovfHit && clrBit;
      strobes.baseWr = baseHit;
      strobes.ctlWr  = ctlHit;
    end else if (regRead) begin
      strobes.rd = 1'b1;
      if (qHit)         strobes.src = RD_QUEUE;
      else if (pHit)    strobes.src = RD_PEND;
      else if (ovfHit)  strobes.src = RD_OVF;
      else if (baseHit) strobes.src = RD_BASE;
      else if (ctlHit)  strobes.src = RD_CTL;
    end
  end

endmodule

// File: rtl/qm_datapath.sv
module qm_datapath
  import qm_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_QUEUES  = 160,
  parameter int QDEPTH      = 4,
  parameter int NUM_PEND    = 5,
  parameter int FIRST_IRQ_Q = 93
) (
  input  logic              clk,
  input  logic              rstN,
  input  qmStrobes_t        strobes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              irq,
  output logic              ovfFlag
);

  localparam int PTR_W  = $clog2(QDEPTH);
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int SLOTS  = NUM_QUEUES * QDEPTH;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int FLAT_W = NUM_PEND * PEND_W;

  logic [DATA_W-1:0] mem [SLOTS];
  logic [PTR_W-1:0]  wrPtr [NUM_QUEUES];
  logic [PTR_W-1:0]  rdPtr [NUM_QUEUES];
  logic [CNT_W-1:0]  cnt [NUM_QUEUES];
  logic [NUM_QUEUES-1:0] notEmpty;
  logic [FLAT_W-1:0] pendFlat;

  logic [CNT_W-1:0]  curCnt;
  logic              qFull;
  logic              qEmpty;
  logic              doPush;
  logic              doPop;
  logic [SLOT_W-1:0] wrSlot;
  logic [SLOT_W-1:0] rdSlot;
  logic [DATA_W-1:0] regionBase;
  logic [DATA_W-1:0] regionCtl;

  always_comb begin
    curCnt = cnt[strobes.qIdx];
    qFull  = (curCnt == CNT_W'(QDEPTH));
    qEmpty = (curCnt == '0);
    doPush = strobes.push && !qFull;
    doPop  = strobes.rd && (strobes.src == RD_QUEUE) && !qEmpty;
    wrSlot = SLOT_W'(strobes.qIdx) * SLOT_W'(QDEPTH) + SLOT_W'(wrPtr[strobes.qIdx]);
    rdSlot = SLOT_W'(strobes.qIdx) * SLOT_W'(QDEPTH) + SLOT_W'(rdPtr[strobes.qIdx]);
  end

  // Entry storage: no reset, occupancy lives in the counters
  always_ff @(posedge clk) begin
    if (doPush) mem[wrSlot] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        wrPtr[q] <= '0;
        rdPtr[q] <= '0;
        cnt[q]   <= '0;
      end
    end else if (doPush) begin
      wrPtr[strobes.qIdx] <= wrPtr[strobes.qIdx] + 1'b1;
      cnt[strobes.qIdx]   <= curCnt + 1'b1;
    end else if (doPop) begin
      rdPtr[strobes.qIdx] <= rdPtr[strobes.qIdx] + 1'b1;
      cnt[strobes.qIdx]   <= curCnt - 1'b1;
    end
  end

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_occ
    assign notEmpty[q] = (cnt[q] != '0);
  end

  always_comb begin
    pendFlat                   = '0;
    pendFlat[NUM_QUEUES-1:0]   = notEmpty;
  end

  assign irq = |notEmpty[NUM_QUEUES-1:FIRST_IRQ_Q];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag    <= 1'b0;
      regionBase <= '0;
      regionCtl  <= '0;
    end else begin
      if (strobes.push && qFull) ovfFlag <= 1'b1;
      else if (strobes.ovfClr)   ovfFlag <= 1'b0;
      if (strobes.baseWr) regionBase <= wdata;
      if (strobes.ctlWr)  regionCtl  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= strobes.rd;
      if (strobes.rd) begin
        case (strobes.src)
          RD_QUEUE: rdata <= doPop ? mem[rdSlot] : '0;
          RD_PEND:  rdata <= DATA_W'(pendFlat[int'(strobes.pendIdx) * PEND_W +: PEND_W]);
          RD_OVF:   rdata <= DATA_W'(ovfFlag);
          RD_BASE:  rdata <= regionBase;
          RD_CTL:   rdata <= regionCtl;
          default:  rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/qdesc_qmgr.sv
module qdesc_qmgr
  import qm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int NUM_QUEUES  = 160,
  parameter int QDEPTH      = 4,
  parameter int FIRST_IRQ_Q = 93
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRvalid,
  output logic              irq
);

  localparam int NUM_PEND = (NUM_QUEUES + PEND_W - 1) / PEND_W;

  qmStrobes_t strobes;
  logic       ovfFlag;

  qm_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_QUEUES(NUM_QUEUES),
    .NUM_PEND  (NUM_PEND)
  ) u_ctrl (
    .regAddr (regAddr),
    .regWrite(regWrite),
    .regRead (regRead),
    .clrBit  (regWdata[0]),
    .strobes (strobes)
  );

  qm_datapath #(
    .DATA_W     (DATA_W),
    .NUM_QUEUES (NUM_QUEUES),
    .QDEPTH     (QDEPTH),
    .NUM_PEND   (NUM_PEND),
    .FIRST_IRQ_Q(FIRST_IRQ_Q)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .rvalid (regRvalid),
    .irq    (irq),
    .ovfFlag(ovfFlag)
  );

endmodule

// File: rtl/qm_checker.sv
module qm_checker (
  input logic clk,
  input logic rstN,
  input logic regWrite,
  input logic regRead,
  input logic regRvalid,
  input logic irq,
  input logic ovfFlag
);

  // R9
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && !regWrite) |=> regRvalid);

  // R9
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRvalid |-> $past(regRead && !regWrite));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(regWrite));

  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regRead && !regWrite));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(regWrite));

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(regWrite));

endmodule

bind qdesc_qmgr qm_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrite (regWrite),
  .regRead  (regRead),
  .regRvalid(regRvalid),
  .irq      (irq),
  .ovfFlag  (ovfFlag)
);

// File: tb/qdesc_qmgr_bench.sv
module qdesc_qmgr_bench;

  localparam int NQ = 160;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrite = 1'b0;
  logic        regRead = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRvalid;
  logic        irq;

  always #5 clk = ~clk;

  qdesc_qmgr u_qdesc_qmgr (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regRead(regRead), .regWdata(regWdata), .regRdata(regRdata),
    .regRvalid(regRvalid), .irq(irq)
  );

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] model [NQ][$];
  logic [31:0] expData[$];
  string       expTag[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned read against the scoreboard
  always @(negedge clk) begin
    if (rstN && regRvalid) begin
      if (expData.size() == 0) begin
        check(1'b0, "R9 unexpected read data", regRdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expData.pop_front();
        t = expTag.pop_front();
        check(regRdata == e, t, regRdata, e);
      end
    end
  end

  function automatic logic [15:0] qAddr(input int q);
    return 16'(32'h200C + 32'h10 * q);
  endfunction

  function automatic logic [31:0] pendExp(input int i);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) begin
      if ((32 * i + b) < NQ && model[32 * i + b].size() > 0) v[b] = 1'b1;
    end
    return v;
  endfunction

  function automatic bit irqExp();
    for (int q = 93; q < NQ; q++) if (model[q].size() > 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, input logic [31:0] exp, input string tag);
    expData.push_back(exp);
    expTag.push_back(tag);
    @(negedge clk);
    regAddr = a; regRead = 1'b1;
    @(negedge clk);
    regRead = 1'b0;
  endtask

  task automatic doPush(input int q, input logic [31:0] d);
    busWrite(qAddr(q), d);
    if (model[q].size() < DEPTH) model[q].push_back(d);
  endtask

  task automatic doPop(input int q, input string tag);
    logic [31:0] e;
    e = (model[q].size() > 0) ? model[q].pop_front() : 32'h0;
    busRead(qAddr(q), e, tag);
  endtask

  task automatic checkPend(input int i, input string tag);
    busRead(16'(32'h90 + 4 * i), pendExp(i), tag);
  endtask

  task automatic checkIrq(input string tag);
    @(negedge clk);
    check(irq == irqExp(), tag, 32'(irq), 32'(irqExp()));
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(regRvalid == 1'b0, "R1 rvalid after reset", 32'(regRvalid), 32'h0);
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    for (int i = 0; i < 5; i++) checkPend(i, "R1 pending after reset");

    // R2 FIFO order on one queue
    doPush(5, 32'h1000_0100);
    doPush(5, 32'h1000_0200);
    doPush(5, 32'h1000_0300);
    checkPend(0, "R5 pending q5 set");
    for (int k = 0; k < 3; k++) doPop(5, "R2 fifo order q5");
    // R4 empty queue
    doPop(5, "R4 pop empty returns zero");
    checkPend(0, "R4 queue stays empty");

    // R3 size hint in low bits, (64-24)/4 = 10
    doPush(20, 32'h8000_0040 | 32'd10);
    doPush(20, 32'h0000_FFE0 | 32'd2);
    doPop(20, "R3 hint preserved first");
    doPop(20, "R3 hint preserved second");

    // R5 / R6 pending bitmap and interrupt range
    doPush(37, 32'hA000_0000);
    doPush(0, 32'hB000_0000);
    doPush(92, 32'hC000_0000);
    checkPend(0, "R5 pending reg0 bit0");
    checkPend(1, "R5 pending reg1 bit5");
    checkPend(2, "R5 pending reg2 bit28");
    checkIrq("R6 queues below 93 keep irq low");
    doPush(93, 32'hD000_0000);
    checkIrq("R6 queue 93 raises irq");
    doPush(150, 32'hE000_0000);
    doPop(93, "R2 pop q93");
    checkIrq("R6 irq held by q150");
    doPop(150, "R2 pop q150");
    checkIrq("R6 irq drops when completion queues empty");
    doPush(159, 32'hF000_0000);
    checkPend(4, "R5 pending reg4 bit31");
    checkIrq("R6 queue 159 raises irq");
    doPop(159, "R2 pop q159");
    checkIrq("R6 irq low after q159 pop");
    doPop(0, "R2 pop q0");
    doPop(37, "R2 pop q37");
    doPop(92, "R2 pop q92");
    for (int i = 0; i < 5; i++) checkPend(i, "R5 all pending cleared");

    // R7 overflow
    busRead(16'h00C0, 32'h0, "R7 overflow clear initially");
    for (int k = 0; k < 5; k++) doPush(7, 32'h0700_0000 + 32'(k));
    busRead(16'h00C0, 32'h1, "R7 overflow set");
    busWrite(16'h00C0, 32'h0);
    busRead(16'h00C0, 32'h1, "R7 write 0 keeps overflow");
    for (int k = 0; k < 5; k++) doPop(7, "R7 full queue contents kept");
    busWrite(16'h00C0, 32'h1);
    busRead(16'h00C0, 32'h0, "R7 overflow cleared");

    // R8 region registers
    busWrite(16'h1000, 32'h8123_4000);
    busWrite(16'h1004, 32'h0080_0302);
    busRead(16'h1000, 32'h8123_4000, "R8 region base readback");
    busRead(16'h1004, 32'h0080_0302, "R8 region control readback");

    // R9 unmapped read
    busRead(16'h0500, 32'h0, "R9 unmapped read zero");
    busRead(16'h2008, 32'h0, "R9 non-pop slot offset reads zero");
    @(negedge clk);
    check(regRvalid == 1'b0, "R9 rvalid low when idle", 32'(regRvalid), 32'h0);

    // R10 unmapped writes ignored
    busWrite(16'h2008 + 16'h30, 32'h1234_5678);
    busWrite(16'h0500, 32'h1234_5678);
    busWrite(16'h0094, 32'hFFFF_FFFF);
    checkPend(0, "R10 pending unchanged");
    doPop(3, "R10 queue 3 still empty");
    busRead(16'h1000, 32'h8123_4000, "R10 region base unchanged");

    repeat (4) @(negedge clk);
    check(expData.size() == 0, "R9 all reads returned", 32'(expData.size()), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule